// File: doc/BRIEF.md
# DDR Command Turnaround Scheduler

This block sits on the controller side of a double-data-rate graphics memory interface. It takes read and write requests one at a time over a valid/ready handshake, each tagged with the external rank it targets. It issues them as commands on the command clock, strictly in arrival order. A request is held off by dropping `req_ready` until the spacing from the previous command is satisfied. The spacing depends on the kind of turnaround: read after read on one rank, read after read across ranks, write after write, write after read, and read after write.

The block also produces the write strobe and the write data, at a resolution of one quarter of a command clock. A write's command cycle doubles as the strobe preamble, with the strobe held low through that cycle's falling clock edge. The first rising strobe edge falls exactly one clock after the command. The data beats change a quarter clock away from each strobe edge, so every edge lies in the middle of a beat's valid window. Writes issued back to back share one continuous strobe. In that case the second write needs no preamble of its own.

Top module: `ddr_turnaround_sched`

## Requirements
- R1: Reset and idle state. With no command issued since reset, `req_ready` is 1. `cmd_valid` is 0, `wdqs_oe` is 0, and `wdqs_q` and `wdq_q` are zero.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) appears in the next cycle as `cmd_valid`, with the same `cmd_write` and `cmd_rank`. No command appears without an acceptance.
- R3: A read following a read to the same rank needs a spacing of at least BL/2 clocks between the two command cycles (2 by default), which gives gapless data.
- R4: A read following a read to a different rank needs at least BL/2+1 clocks, which leaves one strobe-free clock between the two bursts.
- R5: A write following a write needs at least BL/2 clocks, whatever the ranks.
- R6: A read following a write needs at least BL/2+2 clocks. The last data-in strobe edge falls in the middle of clock cmd+BL/2, and the read must come at least 1.5 clocks later.
- R7: A write following a read needs at least CL+BL/2+FLIGHT clocks, so the returning read postamble cannot meet the write preamble.
- R8: Spacing is measured only from the immediately preceding command. A request that is held waiting is accepted on the first cycle its spacing is met, so the command gap equals the minimum exactly.
- R9: In the command cycle of a write that does not follow another write's burst gaplessly, `wdqs_oe` is 1 and `wdqs_q` is 4'b0000. This is the preamble: the strobe stays low through the falling clock edge.
- R10: `wdqs_q` carries the strobe level for each quarter, with bit i for quarter i. In each of the BL/2 data clocks after a write command, `wdqs_q` is 4'b0011. The first rising edge therefore falls exactly one clock after the command.
- R11: Beat j of a write is `req_wdata[j*DW +: DW]`, and quarter i of the data bus is `wdq_q[i*DW +: DW]`. In data clock k, counted from 0, quarter 0 carries beat 2k and quarters 1 and 2 carry beat 2k+1. Quarter 3 carries beat 2k+2. On the last data clock it instead carries beat 0 of a write issued in that cycle, or zero if there is none. In a preamble cycle, quarter 3 carries beat 0.
- R12: `wdqs_oe` drops in the cycle after the last data clock unless a write follows gaplessly. This gives a half-clock low postamble. While `wdqs_oe` is 0, `wdqs_q` and `wdq_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_rank | input | RANK_W | External rank of the request |
| req_wdata | input | BL*DW | Write burst, beat j at bits j*DW upward |
| req_ready | output | 1 | Spacing met; request accepted this edge if valid |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_write | output | 1 | Issued command is a write |
| cmd_rank | output | RANK_W | Rank of issued command |
| wdqs_oe | output | 1 | Write strobe driven |
| wdqs_q | output | 4 | Write strobe level per quarter clock, bit i for quarter i |
| wdq_q | output | 4*DW | Write data per quarter clock, quarter i at bits i*DW upward |

## Verification
Directed pairs hold each second request valid while its predecessor is still in flight. They cover same-rank reads, cross-rank reads, write then write, write then read, and read then write. The measured command distance separates each turnaround rule from the others, and an early or late acceptance shows as a wrong gap. A long random stream over two ranks, with random idle cycles and held requests, compares `req_ready` every cycle against the rule that applies. It also tracks every write's strobe and quarter-by-quarter data. Random back-to-back writes set the merged-preamble case, with its shared strobe and beat 0 placed in the last quarter, apart from the isolated-write case with its own low preamble and postamble.

// File: rtl/ddr_turnaround_sched.sv
module ddr_turnaround_sched #(
  parameter int DW     = 8,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int FLIGHT = 1,
  parameter int RANK_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [RANK_W-1:0]   req_rank,
  input  logic [BL*DW-1:0]    req_wdata,
  output logic                req_ready,
  output logic                cmd_valid,
  output logic                cmd_write,
  output logic [RANK_W-1:0]   cmd_rank,
  output logic                wdqs_oe,
  output logic [3:0]          wdqs_q,
  output logic [4*DW-1:0]     wdq_q
);

  localparam int HB       = BL / 2;
  localparam int GAP_RR   = HB;
  localparam int GAP_RR_X = HB + 1;
  localparam int GAP_WW   = HB;
  localparam int GAP_WR   = HB + 2;
  localparam int GAP_RW   = CL + HB + FLIGHT;
  localparam int GAP_MAX  = (GAP_RW > GAP_WR) ? GAP_RW : GAP_WR;
  localparam int CW       = $clog2(GAP_MAX + 1);
  localparam int KW       = (HB > 1) ? $clog2(HB) : 1;

  logic              seen, last_wr;
  logic [RANK_W-1:0] last_rank;
  logic [CW-1:0]     since, need;
  logic              take;

  always_comb begin
    if (last_wr)        need = req_write ? CW'(GAP_WW) : CW'(GAP_WR);
    else if (req_write) need = CW'(GAP_RW);
    else                need = (req_rank == last_rank) ? CW'(GAP_RR) : CW'(GAP_RR_X);
  end

  assign req_ready = !seen || (since >= need);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_wr   <= 1'b0;
      last_rank <= '0;
      since     <= '0;
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
      cmd_rank  <= '0;
    end else begin
      cmd_valid <= take;
      if (take) begin
        seen      <= 1'b1;
        last_wr   <= req_write;
        last_rank <= req_rank;
        since     <= CW'(1);
        cmd_write <= req_write;
        cmd_rank  <= req_rank;
      end else if (since != CW'(GAP_MAX)) begin
        since <= since + CW'(1);
      end
    end
  end

  logic              nxt_on, cur_on;
  logic [KW-1:0]     cur_k;
  logic [BL*DW-1:0]  nxt_d, cur_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_on <= 1'b0;
      cur_on <= 1'b0;
      cur_k  <= '0;
      nxt_d  <= '0;
      cur_d  <= '0;
    end else begin
      nxt_on <= take && req_write;
      if (take && req_write) nxt_d <= req_wdata;
      if (nxt_on) begin
        cur_on <= 1'b1;
        cur_k  <= '0;
        cur_d  <= nxt_d;
      end else if (cur_on) begin
        if (cur_k == KW'(HB - 1)) cur_on <= 1'b0;
        else                      cur_k  <= cur_k + KW'(1);
      end
    end
  end

  assign wdqs_oe = cur_on || nxt_on;
  assign wdqs_q  = cur_on ? 4'b0011 : 4'b0000;

  always_comb begin
    int b;
    b     = 2 * int'(cur_k);
    wdq_q = '0;
    if (cur_on) begin
      wdq_q[0*DW +: DW] = cur_d[b*DW +: DW];
      wdq_q[1*DW +: DW] = cur_d[(b+1)*DW +: DW];
      wdq_q[2*DW +: DW] = cur_d[(b+1)*DW +: DW];
      if (cur_k != KW'(HB - 1)) wdq_q[3*DW +: DW] = cur_d[(b+2)*DW +: DW];
    end
    if (nxt_on) wdq_q[3*DW +: DW] = nxt_d[0 +: DW];
  end

  logic              a_seen, a_wr;
  logic [RANK_W-1:0] a_rank;
  logic [CW-1:0]     a_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen  <= 1'b0;
      a_wr    <= 1'b0;
      a_rank  <= '0;
      a_since <= '0;
    end else if (cmd_valid) begin
      a_seen  <= 1'b1;
      a_wr    <= cmd_write;
      a_rank  <= cmd_rank;
      a_since <= CW'(1);
    end else if (a_since != CW'(GAP_MAX)) begin
      a_since <= a_since + CW'(1);
    end
  end

  // R2
  cmd_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(req_valid && req_ready));
  // R3
  rd_rd_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && a_seen && !a_wr && cmd_rank == a_rank) |-> a_since >= CW'(GAP_RR));
  // R4
  rd_rd_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && a_seen && !a_wr && cmd_rank != a_rank) |-> a_since >= CW'(GAP_RR_X));
  // R5
  wr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && a_seen && a_wr) |-> a_since >= CW'(GAP_WW));
  // R6
  wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && a_seen && a_wr) |-> a_since >= CW'(GAP_WR));
  // R7
  rd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && a_seen && !a_wr) |-> a_since >= CW'(GAP_RW));
  // R9
  preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdqs_oe) |-> (wdqs_q == 4'b0000) && cmd_valid && cmd_write);
  // R10
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |=> wdqs_oe && (wdqs_q == 4'b0011));
  // R12
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdqs_oe) |-> $past(wdqs_q) == 4'b0011);

endmodule

// File: tb/sim_ddr_turnaround_sched.sv
module sim_ddr_turnaround_sched;
  localparam int DW = 8, BL = 4, CL = 2, FLIGHT = 1, RW = 2, HB = BL / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [RW-1:0] req_rank = '0;
  logic [BL*DW-1:0] req_wdata = '0;
  logic req_ready, cmd_valid, cmd_write, wdqs_oe;
  logic [RW-1:0] cmd_rank;
  logic [3:0] wdqs_q;
  logic [4*DW-1:0] wdq_q;

  always #10 clk = ~clk;

  ddr_turnaround_sched #(.DW(DW), .BL(BL), .CL(CL), .FLIGHT(FLIGHT), .RANK_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_rank(req_rank), .req_wdata(req_wdata), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_rank(cmd_rank),
    .wdqs_oe(wdqs_oe), .wdqs_q(wdqs_q), .wdq_q(wdq_q));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit m_seen = 0, m_wr = 0;
  int m_rank = 0, m_cmdcyc = 0;
  bit p_cmd = 0, p_wr = 0;
  int p_rank = 0;
  logic           e_oe [16];
  logic [3:0]     e_dqs[16];
  logic [4*DW-1:0] e_dq[16];
  bit e_cmdw[16];

  function automatic int need_of(bit pw, int pr, bit nw, int nr);
    if (pw) return nw ? HB : HB + 2;
    if (nw) return CL + HB + FLIGHT;
    return (nr == pr) ? HB : HB + 1;
  endfunction

  function automatic string tag_of(bit pw, int pr, bit nw, int nr);
    if (pw) return nw ? "R5" : "R6";
    if (nw) return "R7";
    return (nr == pr) ? "R3" : "R4";
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic fill_write(int c, logic [BL*DW-1:0] d);
    int i;
    i = c % 16;
    e_oe[i] = 1'b1;
    e_cmdw[i] = 1'b1;
    e_dq[i][3*DW +: DW] = d[0 +: DW];
    for (int k = 0; k < HB; k++) begin
      i = (c + 1 + k) % 16;
      e_oe[i] = 1'b1;
      e_dqs[i] = 4'b0011;
      e_dq[i][0*DW +: DW] = d[(2*k)*DW +: DW];
      e_dq[i][1*DW +: DW] = d[(2*k+1)*DW +: DW];
      e_dq[i][2*DW +: DW] = d[(2*k+1)*DW +: DW];
      if (k < HB - 1) e_dq[i][3*DW +: DW] = d[(2*k+2)*DW +: DW];
    end
  endtask

  task automatic step(bit v, bit w, int r, logic [BL*DW-1:0] d, output bit took);
    int i;
    bit er;
    @(negedge clk);
    cyc++;
    i = cyc % 16;
    chk("R2", "cmd_valid", 64'(cmd_valid), 64'(p_cmd));
    if (p_cmd) begin
      chk("R2", "cmd_write", 64'(cmd_write), 64'(p_wr));
      chk("R2", "cmd_rank", 64'(cmd_rank), 64'(p_rank));
    end
    chk("R12", "wdqs_oe", 64'(wdqs_oe), 64'(e_oe[i]));
    chk((e_cmdw[i] && e_dqs[i] == 4'b0000) ? "R9" : "R10", "wdqs_q", 64'(wdqs_q), 64'(e_dqs[i]));
    chk("R11", "wdq_q", 64'(wdq_q), 64'(e_dq[i]));
    e_oe[i] = 1'b0; e_dqs[i] = '0; e_dq[i] = '0; e_cmdw[i] = 1'b0;
    p_cmd = 0;
    req_valid = v; req_write = w; req_rank = RW'(r); req_wdata = d;
    #1;
    er = !m_seen || ((cyc + 1 - m_cmdcyc) >= need_of(m_wr, m_rank, w, r));
    chk(m_seen ? tag_of(m_wr, m_rank, w, r) : "R1", "req_ready", 64'(req_ready), 64'(er));
    took = v && er;
    if (took) begin
      p_cmd = 1; p_wr = w; p_rank = r;
      m_seen = 1; m_wr = w; m_rank = r; m_cmdcyc = cyc + 1;
      if (w) fill_write(cyc + 1, d);
    end
  endtask

  task automatic idle(int n);
    bit t;
    for (int j = 0; j < n; j++) step(0, 0, 0, '0, t);
  endtask

  task automatic issue(bit w, int r, logic [BL*DW-1:0] d, output int ccyc);
    bit t;
    t = 0;
    for (int j = 0; j < 20 && !t; j++) step(1, w, r, d, t);
    ccyc = cyc + 1;
  endtask

  task automatic pair(bit w1, int r1, bit w2, int r2);
    int c1, c2;
    issue(w1, r1, $urandom, c1);
    issue(w2, r2, $urandom, c2);
    // R8: held request taken on the first legal cycle
    chk("R8", "command gap", 64'(c2 - c1), 64'(need_of(w1, r1, w2, r2)));
    idle(10);
  endtask

  initial begin
    bit t, hold_v, hold_w;
    int hold_r;
    logic [BL*DW-1:0] hold_d;
    void'($urandom(32'd20240607));
    for (int j = 0; j < 16; j++) begin
      e_oe[j] = 0; e_dqs[j] = '0; e_dq[j] = '0; e_cmdw[j] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset cmd_valid", 64'(cmd_valid), 64'(0));
    chk("R1", "reset wdqs_oe", 64'(wdqs_oe), 64'(0));
    chk("R1", "reset wdq_q", 64'(wdq_q), 64'(0));
    chk("R1", "reset req_ready", 64'(req_ready), 64'(1));
    rst_n = 1'b1;
    idle(4);
    pair(0, 0, 0, 0);
    pair(0, 0, 0, 1);
    pair(1, 0, 1, 1);
    pair(1, 1, 0, 1);
    pair(0, 1, 1, 1);
    pair(0, 1, 1, 0);
    pair(1, 0, 1, 0);
    hold_v = 0; hold_w = 0; hold_r = 0; hold_d = '0;
    for (int n = 0; n < 3000; n++) begin
      if (!hold_v) begin
        hold_v = ($urandom % 4) != 0;
        hold_w = $urandom % 2;
        hold_r = $urandom % 2;
        hold_d = $urandom;
      end
      step(hold_v, hold_w, hold_r, hold_d, t);
      if (t) hold_v = 0;
    end
    idle(12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule